// File: doc/BRIEF.md
# I2C Master Command Register Bank

This block is a byte-wide register bank that a CPU uses to drive a simple I2C master. It stores the master and slave data, address, control, mode, transfer-count, extended-control, direct-control and interrupt bytes. It turns CPU register accesses into byte-level commands for a separate bit-level bus engine. Those commands are start (with a 7-bit target address and a direction), send a byte, receive a byte and stop. The block updates its status flags from the acknowledge result that the engine returns for each command.

Transfers start implicitly. A CPU write of the master data byte while the bus is idle first addresses the target for writing and then sends the byte. A read sequence is armed through the control byte. Each read of the master data byte receives one byte, and while the two-bit pending count in the control byte is nonzero, the block stops and re-addresses the target after the byte. The CPU port stalls, with ready low, while bus commands are outstanding. The read or write acknowledge pulse is held back until the engine reports the last command done.

Top module: `i2c_mreg_bank`

## Requirements
- R1: After reset, or on a read of an unmapped offset, the readable bytes are zero, except the extended status byte at 0x09, which reads 0x8F, and the direct control byte at 0x10, which reads 0x0F.
- R2: Plain bytes store what is written and read it back: slave data 0x02, master address high 0x05, slave address low 0x0A and high 0x0B, interrupt 0x11, and 0x0F when its bit 0 is clear. Mode control at 0x07 keeps the written value ANDed with 0xDF, transfer count at 0x0E ANDed with 0x77, and direct control ANDed with 0x07. The status byte (0x08) and extended status byte (0x09) ignore writes.
- R3: A write of the master data byte (0x00) while no transfer is active issues a start to the address in bits 7:1 of the master address low byte (0x04), with direction bit 0 meaning write. On ACK the block sets status bit 0 (transfer in progress), clears status bit 2 (error), clears the extended status to 0x00 and then sends the byte. On NACK it clears bit 0, sets bit 2, sets extended status bit 0 (failed transfer) and sends nothing. While a transfer is active, only the send is issued.
- R4: A send that is not acknowledged clears status bit 0, sets status bit 2 and extended status bit 0, and is followed by a stop.
- R5: A write to control (0x06) with bit 0 (start) and bit 1 (read) both set first stops any active transfer and clears status bit 0, then issues a start with direction read. On ACK it sets status bit 5 (data buffered), clears bit 2 and clears the extended status to 0x00. On NACK it clears bit 0 and sets bit 2 and extended status bit 0.
- R6: A control write with bit 0 set and bit 1 clear clears status bit 0 and issues no bus command.
- R7: A read of the master data byte while status bit 5 is clear returns 0xFF and issues no bus command.
- R8: A read of the master data byte while status bit 5 is set issues a receive and returns the received byte, or 0xFF if the engine flags failure. If control bits 5:4 (pending) are zero, it clears status bit 5. Otherwise it issues a stop and then a read start that is handled as in R5. Pending is then decremented, saturating at zero, and the other control bits are left unchanged.
- R9: A write of the master address low byte while a transfer is active issues a stop.
- R10: A write to 0x0F with bit 0 set returns every register to its reset value and stores nothing else.
- R11: Commands use a valid/ready pair with opcode 0 start, 1 send, 2 receive and 3 stop. The opcode, direction, address and data stay stable while valid waits for ready. The engine's done pulse, carrying ACK and the received byte, comes at least one cycle after acceptance. CPU requests are only taken while the CPU ready output is high, and that output is low while any command is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Register byte offset |
| cpu_wdata_i | input | 8 | Write data |
| cpu_ready_o | output | 1 | Block can take a request |
| cpu_ack_o | output | 1 | Access complete pulse |
| cpu_rdata_o | output | 8 | Read data, valid with ack |
| cmd_valid_o | output | 1 | Bus command valid |
| cmd_ready_i | input | 1 | Engine accepts command |
| cmd_op_o | output | 2 | Command opcode |
| cmd_rnw_o | output | 1 | Start direction, 1 = read |
| cmd_addr_o | output | 7 | Target address for start |
| cmd_data_o | output | 8 | Byte to send |
| rsp_done_i | input | 1 | Command finished pulse |
| rsp_ack_i | input | 1 | Command acknowledged |
| rsp_data_i | input | 8 | Received byte |

## Verification
The bench goes after the transitions between implicit and explicit transfers. It covers a data write right after a NACKed send, where a design that forgot to drop the active flag would send without re-addressing. It covers a read-start control write while a write is still active, where a missing stop would leave the old transfer open. It runs the pending count down through two, one and zero, past saturation. A wrapping design would leave 3 in the field, and one that dropped the re-address would return bytes without the stop and start pair. It also checks a NACKed address on both directions, the empty-buffer 0xFF read, the write masks, and a soft reset that must restore 0x8F and 0x0F rather than zero.

// File: rtl/i2c_mreg_pkg.sv
package i2c_mreg_pkg;

  localparam int BYTE_W = 8;
  localparam int TADDR_W = 7;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_WSTART,
    SQ_SEND,
    SQ_SSTOP,
    SQ_CSTOP,
    SQ_RSTART,
    SQ_LSTOP,
    SQ_RECV,
    SQ_RSTOP
  } seq_e;

  localparam logic [7:0] OFF_MDATA = 8'h00;
  localparam logic [7:0] OFF_SDATA = 8'h02;
  localparam logic [7:0] OFF_MADRL = 8'h04;
  localparam logic [7:0] OFF_MADRH = 8'h05;
  localparam logic [7:0] OFF_CTRL  = 8'h06;
  localparam logic [7:0] OFF_MODE  = 8'h07;
  localparam logic [7:0] OFF_STAT  = 8'h08;
  localparam logic [7:0] OFF_XSTAT = 8'h09;
  localparam logic [7:0] OFF_SADRL = 8'h0A;
  localparam logic [7:0] OFF_SADRH = 8'h0B;
  localparam logic [7:0] OFF_XCNT  = 8'h0E;
  localparam logic [7:0] OFF_XCTL  = 8'h0F;
  localparam logic [7:0] OFF_DIR   = 8'h10;
  localparam logic [7:0] OFF_IRQ   = 8'h11;

  localparam logic [7:0] MODE_MASK = 8'hDF;
  localparam logic [7:0] XCNT_MASK = 8'h77;
  localparam logic [7:0] DIR_MASK  = 8'h07;

  typedef struct packed {
    logic [7:0] mdata;
    logic [7:0] sdata;
    logic [7:0] madrl;
    logic [7:0] madrh;
    logic [7:0] ctrl;
    logic [7:0] mode;
    logic [7:0] sadrl;
    logic [7:0] sadrh;
    logic [7:0] xcnt;
    logic [7:0] xctl;
    logic [7:0] dir;
    logic [7:0] irq;
    logic [7:0] xstat;
    logic       busy;
    logic       err;
    logic       bufd;
  } reg_bank_t;

  localparam reg_bank_t REG_RST = '{xstat: 8'h8F, dir: 8'h0F, default: '0};

endpackage

// File: rtl/i2c_mreg_cmd.sv
module i2c_mreg_cmd
  import i2c_mreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  bus_op_e           op_i,
  input  logic              rnw_i,
  output logic              idle_o,
  output logic              fin_o,
  output logic              ack_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output bus_op_e           cmd_op_o,
  output logic              cmd_rnw_o,
  input  logic              rsp_done_i,
  input  logic              rsp_ack_i,
  input  logic [BYTE_W-1:0] rsp_data_i
);

  typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_WAIT} ph_e;

  ph_e     ph_q;
  bus_op_e op_q;
  logic    rnw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      op_q  <= OP_STOP;
      rnw_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (go_i) begin
          op_q  <= op_i;
          rnw_q <= rnw_i;
          ph_q  <= PH_REQ;
        end
        PH_REQ:  if (cmd_ready_i) ph_q <= PH_WAIT;
        PH_WAIT: if (rsp_done_i) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign idle_o      = (ph_q == PH_IDLE);
  assign cmd_valid_o = (ph_q == PH_REQ);
  assign cmd_op_o    = op_q;
  assign cmd_rnw_o   = rnw_q;
  assign fin_o       = (ph_q == PH_WAIT) && rsp_done_i;
  assign ack_o       = rsp_ack_i;
  assign data_o      = rsp_data_i;

  // R11
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_rnw_o)));

  // R11
  go_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> idle_o);

endmodule

// File: rtl/i2c_mreg_rdmux.sv
module i2c_mreg_rdmux
  import i2c_mreg_pkg::*;
(
  input  reg_bank_t         rb_i,
  input  logic [7:0]        addr_i,
  output logic [BYTE_W-1:0] data_o
);

  logic [7:0] stat;
  assign stat = {2'b00, rb_i.bufd, 2'b00, rb_i.err, 1'b0, rb_i.busy};

  always_comb begin
    case (addr_i)
      OFF_MDATA: data_o = rb_i.mdata;
      OFF_SDATA: data_o = rb_i.sdata;
      OFF_MADRL: data_o = rb_i.madrl;
      OFF_MADRH: data_o = rb_i.madrh;
      OFF_CTRL:  data_o = rb_i.ctrl;
      OFF_MODE:  data_o = rb_i.mode;
      OFF_STAT:  data_o = stat;
      OFF_XSTAT: data_o = rb_i.xstat;
      OFF_SADRL: data_o = rb_i.sadrl;
      OFF_SADRH: data_o = rb_i.sadrh;
      OFF_XCNT:  data_o = rb_i.xcnt;
      OFF_XCTL:  data_o = rb_i.xctl;
      OFF_DIR:   data_o = rb_i.dir;
      OFF_IRQ:   data_o = rb_i.irq;
      default:   data_o = '0;
    endcase
  end

endmodule

// File: rtl/i2c_mreg_bank.sv
module i2c_mreg_bank
  import i2c_mreg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [7:0]        cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_ack_o,
  output logic [7:0]        cpu_rdata_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic              cmd_rnw_o,
  output logic [6:0]        cmd_addr_o,
  output logic [7:0]        cmd_data_o,
  input  logic              rsp_done_i,
  input  logic              rsp_ack_i,
  input  logic [7:0]        rsp_data_i
);

  localparam int PEND_LO = 4;
  localparam int PEND_HI = 5;

  reg_bank_t         rb_q;
  seq_e              seq_q;
  logic              act_q;
  logic              issued_q;
  logic              rd_q;
  logic [BYTE_W-1:0] rbyte_q;
  logic              ack_q;
  logic [BYTE_W-1:0] rdata_q;

  logic [7:0]        addr8;
  logic              acc;
  logic              issue;
  bus_op_e           iss_op;
  logic              iss_rnw;
  logic              cmd_idle;
  logic              fin;
  logic              fin_ack;
  logic [BYTE_W-1:0] fin_data;
  logic [BYTE_W-1:0] recv_byte;
  logic [BYTE_W-1:0] mux_data;
  logic [1:0]        pend;
  bus_op_e           cmd_op;

  assign addr8       = 8'(cpu_addr_i);
  assign cpu_ready_o = (seq_q == SQ_IDLE);
  assign acc         = cpu_req_i && cpu_ready_o;
  assign issue       = (seq_q != SQ_IDLE) && !issued_q;
  assign pend        = rb_q.ctrl[PEND_HI:PEND_LO];
  assign recv_byte   = fin_ack ? fin_data : 8'hFF;

  always_comb begin
    case (seq_q)
      SQ_WSTART, SQ_RSTART: iss_op = OP_START;
      SQ_SEND:              iss_op = OP_SEND;
      SQ_RECV:              iss_op = OP_RECV;
      default:              iss_op = OP_STOP;
    endcase
  end
  assign iss_rnw = (seq_q == SQ_RSTART);

  i2c_mreg_cmd u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (issue),
    .op_i        (iss_op),
    .rnw_i       (iss_rnw),
    .idle_o      (cmd_idle),
    .fin_o       (fin),
    .ack_o       (fin_ack),
    .data_o      (fin_data),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_op_o    (cmd_op),
    .cmd_rnw_o   (cmd_rnw_o),
    .rsp_done_i  (rsp_done_i),
    .rsp_ack_i   (rsp_ack_i),
    .rsp_data_i  (rsp_data_i)
  );

  i2c_mreg_rdmux u_rdmux (
    .rb_i   (rb_q),
    .addr_i (addr8),
    .data_o (mux_data)
  );

  assign cmd_op_o    = cmd_op;
  assign cmd_addr_o  = rb_q.madrl[7:1];
  assign cmd_data_o  = rb_q.mdata;
  assign cpu_ack_o   = ack_q;
  assign cpu_rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_q     <= REG_RST;
      seq_q    <= SQ_IDLE;
      act_q    <= 1'b0;
      issued_q <= 1'b0;
      rd_q     <= 1'b0;
      rbyte_q  <= '0;
      ack_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      ack_q <= 1'b0;
      if (issue)    issued_q <= 1'b1;
      else if (fin) issued_q <= 1'b0;

      if (acc) begin
        rd_q    <= !cpu_we_i;
        ack_q   <= 1'b1;
        rdata_q <= '0;
        if (cpu_we_i) begin
          case (addr8)
            OFF_MDATA: begin
              rb_q.mdata <= cpu_wdata_i;
              seq_q      <= act_q ? SQ_SEND : SQ_WSTART;
              ack_q      <= 1'b0;
            end
            OFF_SDATA: rb_q.sdata <= cpu_wdata_i;
            OFF_MADRL: begin
              rb_q.madrl <= cpu_wdata_i;
              if (act_q) begin
                seq_q <= SQ_LSTOP;
                ack_q <= 1'b0;
              end
            end
            OFF_MADRH: rb_q.madrh <= cpu_wdata_i;
            OFF_CTRL: begin
              rb_q.ctrl <= cpu_wdata_i;
              if (cpu_wdata_i[0]) begin
                if (cpu_wdata_i[1]) begin
                  ack_q <= 1'b0;
                  if (act_q) begin
                    rb_q.busy <= 1'b0;
                    seq_q     <= SQ_CSTOP;
                  end else begin
                    seq_q <= SQ_RSTART;
                  end
                end else begin
                  rb_q.busy <= 1'b0;
                end
              end
            end
            OFF_MODE:  rb_q.mode  <= cpu_wdata_i & MODE_MASK;
            OFF_SADRL: rb_q.sadrl <= cpu_wdata_i;
            OFF_SADRH: rb_q.sadrh <= cpu_wdata_i;
            OFF_XCNT:  rb_q.xcnt  <= cpu_wdata_i & XCNT_MASK;
            OFF_XCTL: begin
              if (cpu_wdata_i[0]) rb_q <= REG_RST;
              else                rb_q.xctl <= cpu_wdata_i;
            end
            OFF_DIR:   rb_q.dir   <= cpu_wdata_i & DIR_MASK;
            OFF_IRQ:   rb_q.irq   <= cpu_wdata_i;
            default: ;
          endcase
        end else begin
          if (addr8 == OFF_MDATA) begin
            if (rb_q.bufd) begin
              seq_q <= SQ_RECV;
              ack_q <= 1'b0;
            end else begin
              rdata_q <= 8'hFF;
            end
          end else begin
            rdata_q <= mux_data;
          end
        end
      end else if (fin) begin
        case (seq_q)
          SQ_WSTART: begin
            if (fin_ack) begin
              rb_q.busy  <= 1'b1;
              rb_q.err   <= 1'b0;
              rb_q.xstat <= '0;
              act_q      <= 1'b1;
              seq_q      <= SQ_SEND;
            end else begin
              rb_q.busy     <= 1'b0;
              rb_q.err      <= 1'b1;
              rb_q.xstat[0] <= 1'b1;
              seq_q         <= SQ_IDLE;
              ack_q         <= 1'b1;
            end
          end
          SQ_SEND: begin
            if (fin_ack) begin
              seq_q <= SQ_IDLE;
              ack_q <= 1'b1;
            end else begin
              rb_q.busy     <= 1'b0;
              rb_q.err      <= 1'b1;
              rb_q.xstat[0] <= 1'b1;
              seq_q         <= SQ_SSTOP;
            end
          end
          SQ_SSTOP, SQ_LSTOP: begin
            act_q <= 1'b0;
            seq_q <= SQ_IDLE;
            ack_q <= 1'b1;
          end
          SQ_CSTOP, SQ_RSTOP: begin
            act_q <= 1'b0;
            seq_q <= SQ_RSTART;
          end
          SQ_RSTART: begin
            if (fin_ack) begin
              rb_q.bufd  <= 1'b1;
              rb_q.err   <= 1'b0;
              rb_q.xstat <= '0;
              act_q      <= 1'b1;
            end else begin
              rb_q.busy     <= 1'b0;
              rb_q.err      <= 1'b1;
              rb_q.xstat[0] <= 1'b1;
            end
            seq_q   <= SQ_IDLE;
            ack_q   <= 1'b1;
            rdata_q <= rd_q ? rbyte_q : '0;
          end
          SQ_RECV: begin
            rbyte_q <= recv_byte;
            rb_q.ctrl[PEND_HI:PEND_LO] <= (pend == 2'd0) ? 2'd0 : pend - 2'd1;
            if (pend == 2'd0) begin
              rb_q.bufd <= 1'b0;
              seq_q     <= SQ_IDLE;
              ack_q     <= 1'b1;
              rdata_q   <= recv_byte;
            end else begin
              seq_q <= SQ_RSTOP;
            end
          end
          default: seq_q <= SQ_IDLE;
        endcase
      end
    end
  end

  // R11
  cpu_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o || !cmd_idle) |-> !cpu_ready_o);

  // R3
  start_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && seq_q == SQ_WSTART && !fin_ack) |=> (rb_q.err && rb_q.xstat[0] && !rb_q.busy && cpu_ack_o));

  // R7
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !cpu_we_i && addr8 == OFF_MDATA && !rb_q.bufd) |=> (cpu_ack_o && cpu_rdata_o == 8'hFF && !cmd_valid_o));

  // R8
  pend_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && seq_q == SQ_RECV && pend == 2'd0) |=> (rb_q.ctrl[PEND_HI:PEND_LO] == 2'd0 && !rb_q.bufd));

  // R4
  send_nack_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && seq_q == SQ_SEND && !fin_ack) |=> (seq_q == SQ_SSTOP && rb_q.err));

endmodule

// File: tb/i2c_mreg_bank_tb_top.sv
module i2c_mreg_bank_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_req = 1'b0;
  logic       cpu_we = 1'b0;
  logic [4:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       cpu_ready_o, cpu_ack_o;
  logic [7:0] cpu_rdata_o;
  logic       cmd_valid_o;
  logic       cmd_ready = 1'b0;
  logic [1:0] cmd_op_o;
  logic       cmd_rnw_o;
  logic [6:0] cmd_addr_o;
  logic [7:0] cmd_data_o;
  logic       rsp_done = 1'b0;
  logic       rsp_ack = 1'b0;
  logic [7:0] rsp_data = '0;

  always #5 clk = ~clk;

  i2c_mreg_bank #(.ADDR_W(5)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready_o), .cpu_ack_o(cpu_ack_o), .cpu_rdata_o(cpu_rdata_o),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op_o),
    .cmd_rnw_o(cmd_rnw_o), .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o),
    .rsp_done_i(rsp_done), .rsp_ack_i(rsp_ack), .rsp_data_i(rsp_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic busy_m = 1'b0;
  logic [17:0] exp_q[$];
  logic [17:0] obs_q[$];

  // reference model state
  logic [7:0] m_mdata, m_sdata, m_madrl, m_madrh, m_ctrl, m_mode, m_sadrl, m_sadrh;
  logic [7:0] m_xcnt, m_xctl, m_dir, m_irq, m_xstat;
  logic       m_busy, m_err, m_bufd, m_act;
  logic [7:0] m_rx = 8'hC0;
  logic [7:0] e_rx = 8'hC0;

  function automatic logic [17:0] pk(input logic [1:0] op, input logic rnw,
                                     input logic [6:0] a, input logic [7:0] d);
    case (op)
      2'd0:    return {2'd0, rnw, a, 8'h00};
      2'd1:    return {2'd1, 1'b0, 7'h00, d};
      default: return {op, 16'h0000};
    endcase
  endfunction

  function automatic logic tgt(input logic [6:0] a);
    return a == 7'h50;
  endfunction

  task automatic chk(input string rq, input string what, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic m_reset();
    m_mdata = 0; m_sdata = 0; m_madrl = 0; m_madrh = 0; m_ctrl = 0; m_mode = 0;
    m_sadrl = 0; m_sadrh = 0; m_xcnt = 0; m_xctl = 0; m_dir = 8'h0F; m_irq = 0;
    m_xstat = 8'h8F; m_busy = 0; m_err = 0; m_bufd = 0;
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'h02: return m_sdata;
      8'h04: return m_madrl;
      8'h05: return m_madrh;
      8'h06: return m_ctrl;
      8'h07: return m_mode;
      8'h08: return {2'b00, m_bufd, 2'b00, m_err, 1'b0, m_busy};
      8'h09: return m_xstat;
      8'h0A: return m_sadrl;
      8'h0B: return m_sadrh;
      8'h0E: return m_xcnt;
      8'h0F: return m_xctl;
      8'h10: return m_dir;
      8'h11: return m_irq;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_rstart();
    exp_q.push_back(pk(2'd0, 1'b1, m_madrl[7:1], 8'h00));
    if (tgt(m_madrl[7:1])) begin
      m_bufd = 1; m_err = 0; m_xstat = 0; m_act = 1;
    end else begin
      m_busy = 0; m_err = 1; m_xstat[0] = 1'b1;
    end
  endtask

  task automatic m_wr(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h00: begin
        m_mdata = d;
        if (!m_act) begin
          exp_q.push_back(pk(2'd0, 1'b0, m_madrl[7:1], 8'h00));
          if (tgt(m_madrl[7:1])) begin
            m_busy = 1; m_err = 0; m_xstat = 0; m_act = 1;
          end else begin
            m_busy = 0; m_err = 1; m_xstat[0] = 1'b1;
          end
        end
        if (m_act) begin
          exp_q.push_back(pk(2'd1, 1'b0, 7'h00, d));
          if (d == 8'hEE) begin
            m_busy = 0; m_err = 1; m_xstat[0] = 1'b1;
            exp_q.push_back(pk(2'd3, 1'b0, 7'h00, 8'h00));
            m_act = 0;
          end
        end
      end
      8'h02: m_sdata = d;
      8'h04: begin
        m_madrl = d;
        if (m_act) begin
          exp_q.push_back(pk(2'd3, 1'b0, 7'h00, 8'h00));
          m_act = 0;
        end
      end
      8'h05: m_madrh = d;
      8'h06: begin
        m_ctrl = d;
        if (d[0]) begin
          if (d[1]) begin
            if (m_act) begin
              m_busy = 0;
              exp_q.push_back(pk(2'd3, 1'b0, 7'h00, 8'h00));
              m_act = 0;
            end
            m_rstart();
          end else m_busy = 0;
        end
      end
      8'h07: m_mode = d & 8'hDF;
      8'h0A: m_sadrl = d;
      8'h0B: m_sadrh = d;
      8'h0E: m_xcnt = d & 8'h77;
      8'h0F: if (d[0]) m_reset(); else m_xctl = d;
      8'h10: m_dir = d & 8'h07;
      8'h11: m_irq = d;
      default: ;
    endcase
  endtask

  task automatic m_rd0(output logic [7:0] v);
    logic [1:0] p;
    if (!m_bufd) begin
      v = 8'hFF;
      return;
    end
    exp_q.push_back(pk(2'd2, 1'b0, 7'h00, 8'h00));
    v = m_rx;
    m_rx = m_rx + 8'd1;
    p = m_ctrl[5:4];
    if (p == 2'd0) m_bufd = 0;
    else begin
      exp_q.push_back(pk(2'd3, 1'b0, 7'h00, 8'h00));
      m_act = 0;
      m_rstart();
    end
    m_ctrl[5:4] = (p == 2'd0) ? 2'd0 : p - 2'd1;
  endtask

  // bus engine responder
  initial begin
    int stall = 0;
    forever begin
      @(negedge clk);
      if (cmd_valid_o) begin
        repeat (stall) @(negedge clk);
        stall = (stall + 1) % 3;
        obs_q.push_back(pk(cmd_op_o, cmd_rnw_o, cmd_addr_o, cmd_data_o));
        case (cmd_op_o)
          2'd0: begin rsp_ack = tgt(cmd_addr_o); rsp_data = 8'h00; end
          2'd1: begin rsp_ack = (cmd_data_o != 8'hEE); rsp_data = 8'h00; end
          2'd2: begin rsp_ack = 1'b1; rsp_data = e_rx; e_rx = e_rx + 8'd1; end
          default: begin rsp_ack = 1'b1; rsp_data = 8'h00; end
        endcase
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        @(negedge clk);
        rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
      end
    end
  end

  // per-clock idle check against the model
  always @(negedge clk) begin
    if (rst_n && !busy_m) begin
      chk("R11", "idle ready/valid", {16'h0, cpu_ready_o, cmd_valid_o}, {16'h0, 1'b1, 1'b0});
    end
  end

  task automatic cpu_op(input logic we, input logic [7:0] a, input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    busy_m = 1'b1;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a[4:0]; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_ack_o) @(negedge clk);
    rd = cpu_rdata_o;
    busy_m = 1'b0;
  endtask

  task automatic cmp_q(input string rq);
    chk(rq, "command count", 18'(obs_q.size()), 18'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
      chk(rq, "command", obs_q[i], exp_q[i]);
    exp_q.delete();
    obs_q.delete();
  endtask

  task automatic do_wr(input string rq, input logic [7:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    m_wr(a, d);
    cpu_op(1'b1, a, d, dummy);
    cmp_q(rq);
  endtask

  task automatic do_rd(input string rq, input logic [7:0] a);
    logic [7:0] e, g;
    if (a == 8'h00) m_rd0(e);
    else e = m_read(a);
    cpu_op(1'b0, a, 8'h00, g);
    chk(rq, $sformatf("read 0x%02h", a), {10'h0, g}, {10'h0, e});
    cmp_q(rq);
  endtask

  task automatic chk_state(input string rq);
    do_rd(rq, 8'h06);
    do_rd(rq, 8'h08);
    do_rd(rq, 8'h09);
  endtask

  task automatic chk_all(input string rq);
    for (int a = 1; a <= 8'h13; a++) do_rd(rq, 8'(a));
    do_rd(rq, 8'h1F);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    m_reset();
    m_act = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values and unmapped reads
    chk_all("R1");
    // R2 plain storage and masks, read-only status
    do_wr("R2", 8'h02, 8'h5A);
    do_wr("R2", 8'h05, 8'hA5);
    do_wr("R2", 8'h07, 8'hFF);
    do_wr("R2", 8'h0A, 8'h3C);
    do_wr("R2", 8'h0B, 8'hC3);
    do_wr("R2", 8'h0E, 8'hFF);
    do_wr("R2", 8'h0F, 8'h06);
    do_wr("R2", 8'h10, 8'hFF);
    do_wr("R2", 8'h11, 8'h81);
    do_wr("R2", 8'h08, 8'hFF);
    do_wr("R2", 8'h09, 8'h00);
    chk_all("R2");
    // R3 implicit write start, then plain send
    do_wr("R3", 8'h04, 8'hA0);
    do_wr("R3", 8'h00, 8'h12);
    chk_state("R3");
    do_wr("R3", 8'h00, 8'h34);
    // R4 send NACK -> stop
    do_wr("R4", 8'h00, 8'hEE);
    chk_state("R4");
    do_wr("R3", 8'h00, 8'h55);
    chk_state("R3");
    // R5 read start while active, pending 2
    do_wr("R5", 8'h06, 8'h23);
    chk_state("R5");
    // R8 pending countdown and saturation
    do_rd("R8", 8'h00);
    chk_state("R8");
    do_rd("R8", 8'h00);
    chk_state("R8");
    do_rd("R8", 8'h00);
    chk_state("R8");
    // R7 empty buffer read
    do_rd("R7", 8'h00);
    chk_state("R7");
    // R6 start without read
    do_wr("R6", 8'h06, 8'h01);
    chk_state("R6");
    // R9 address write while active
    do_wr("R9", 8'h04, 8'h42);
    // R3 NACKed write start
    do_wr("R3", 8'h00, 8'h77);
    chk_state("R3");
    // R5 NACKed read start
    do_wr("R5", 8'h06, 8'h03);
    chk_state("R5");
    do_wr("R9", 8'h04, 8'hA0);
    do_wr("R5", 8'h06, 8'h13);
    do_rd("R8", 8'h00);
    do_rd("R8", 8'h00);
    chk_state("R8");
    // R10 soft reset
    do_wr("R10", 8'h0F, 8'h01);
    chk_all("R10");
    do_wr("R10", 8'h00, 8'h99);
    chk_state("R10");
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule